// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit linear address into a 32-bit physical address. The address maps through two levels of tables that sit in memory, with 4 KB pages. The ten most significant bits of the linear address select a word in the directory. That word names the frame of a second-level table. The next ten bits select a word in that table, which names the frame of the page. The twelve low bits pass through unchanged as the byte offset. Bit 0 of each table word marks the word as present. If either word has that bit clear, the walk ends with a fault.

Requests enter on a valid/ready handshake. The block reads table words one at a time over a simple memory port, with separate request and response handshakes, and it never has more than one read outstanding. It keeps completed translations in a small fully associative cache, so that a request for a recently translated page is answered without touching memory. When paging is off, the linear address comes straight back as the physical address. Writing the directory base register or pulsing the flush input empties the cache.

Top module: `xlat_walker`

## Requirements
- R1: With `pg_en` low, an accepted request yields `resp_valid` on the next cycle with `resp_pa` equal to `req_lin` and `resp_fault` low, and no memory read is issued, even if the page is cached.
- R2: On a cache miss with paging on, the cycle after acceptance raises `mem_req_valid` with address {`base_pfn` register, `req_lin[31:22]`, 2'b00}.
- R3: After a present directory word (bit 0 = 1) is returned, the next read address is {directory word bits 31:12, `req_lin[21:12]`, 2'b00}.
- R4: After a present table word is returned, `resp_valid` rises on the next cycle with `resp_pa` = {table word bits 31:12, `req_lin[11:0]`} and `resp_fault` low.
- R5: A directory word with bit 0 clear ends the walk: on the next cycle `resp_valid` and `resp_fault` are high, `resp_pa` is zero, and no second read is issued.
- R6: A table word with bit 0 clear gives the same fault response one cycle after that word is returned.
- R7: A request whose page (`req_lin[31:12]`) holds a valid cache entry is answered on the next cycle with the cached frame and the request's offset, and no memory read is issued.
- R8: `req_ready` is high only while the block is idle (including out of reset). `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. `mem_rsp_ready` is high only while a read awaits its data, and at most one read is outstanding.
- R9: The cache holds 8 translations and replaces entries in round-robin order, starting at entry 0 after reset. A ninth distinct fill evicts the first fill.
- R10: A one-cycle `flush` pulse, or a `base_wr` pulse, invalidates every cache entry. `base_wr` also loads `base_pfn` into the directory base register used by later walks.
- R11: Fault results are never cached, so a repeated faulting request walks memory again.
- R12: If the cache is invalidated while a walk is in progress, the walk still completes and responds, but its translation is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| base_wr | input | 1 | Load the directory base register and invalidate the cache |
| base_pfn | input | 20 | New directory frame number (physical base bits 31:12) |
| pg_en | input | 1 | Paging enable; low selects pass-through |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_lin | input | 32 | Linear address to translate |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_pa | output | 32 | Physical address (zero on fault) |
| resp_fault | output | 1 | Not-present fault |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waits for read data |
| mem_rsp_data | input | 32 | Read data word |

## Verification
Pass-through and cache hits are due one cycle after the accepting edge. A directory read request is due one cycle after the accepting edge. The table read request, or a directory fault, is due one cycle after the directory data handshake. The final address, or a table fault, is due one cycle after the table data handshake. The bench drives every input two time units after a rising edge and samples at that same point. Its model states, for every cycle, whether `resp_valid` and `mem_req_valid` should be high. Any early, late or missing strobe is therefore caught on the cycle it happens, not just when a result arrives. Memory stalls of varying length on both handshakes confirm that the request address holds steady and that timing is counted from the handshake rather than from the request.

// File: rtl/xw_pkg.sv
package xw_pkg;

   // Walk sequencer states
   typedef enum logic [2:0] {
      WS_IDLE     = 3'd0,
      WS_DIR_REQ  = 3'd1,
      WS_DIR_WAIT = 3'd2,
      WS_TBL_REQ  = 3'd3,
      WS_TBL_WAIT = 3'd4
   } walk_state_t;

   // Table words are 4 bytes: the index is shifted by this amount
   localparam int WORD_SHIFT = 2;

   // Attribute bit that marks a table word present
   localparam int PRESENT_BIT = 0;

endpackage

// File: rtl/xw_tlb.sv
module xw_tlb #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 20,
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("xw_tlb: DEPTH must be at least 1");
   end
   if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("xw_tlb: tag and data widths must be positive");
   end

   logic [DEPTH-1:0]  ent_hit;
   logic [DATA_W-1:0] ent_data [DEPTH];
   logic [PTR_W-1:0]  victim;
   logic              do_fill;

   assign do_fill = fill_en && !inval;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic              v_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;
      logic              sel;

      assign sel = do_fill && (victim == PTR_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
         end else if (inval) begin
            v_q <= 1'b0;
         end else if (sel) begin
            v_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q  <= fill_tag;
            data_q <= fill_data;
         end
      end

      assign ent_hit[g]  = v_q && (tag_q == lk_tag);
      assign ent_data[g] = data_q;
   end

   always_comb begin
      lk_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ent_hit[i]) lk_data = lk_data | ent_data[i];
      end
   end

   assign lk_hit = |ent_hit;

   // Round-robin victim pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim <= '0;
      end else if (do_fill) begin
         victim <= (victim == LAST) ? '0 : victim + 1'b1;
      end
   end

   AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ent_hit)); // R7
   AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> !lk_hit); // R10
   AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      victim <= LAST); // R9

endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
   import xw_pkg::*;
#(
   parameter int IDX_W = 10,
   parameter int OFF_W = 12,
   parameter int VA_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_lin,
   input  logic                  pg_en,
   input  logic [VA_W-OFF_W-1:0] dir_pfn,
   input  logic                  inval,
   input  logic                  hit,
   input  logic [VA_W-OFF_W-1:0] hit_pfn,
   output logic                  resp_valid,
   output logic [VA_W-1:0]       resp_pa,
   output logic                  resp_fault,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [VA_W-1:0]       mem_req_addr,
   input  logic                  mem_rsp_valid,
   output logic                  mem_rsp_ready,
   input  logic [VA_W-1:0]       mem_rsp_data,
   output logic                  fill_en,
   output logic [VA_W-OFF_W-1:0] fill_vpn,
   output logic [VA_W-OFF_W-1:0] fill_pfn
);

   localparam int PFN_W = VA_W - OFF_W;

   if (IDX_W + WORD_SHIFT != OFF_W) begin : g_bad_geom
      $error("xw_walk_fsm: one table of 4-byte words must fill one page");
   end

   walk_state_t     st;
   logic [VA_W-1:0] lin_q;
   logic [VA_W-1:0] addr_q;
   logic            stale_q;
   logic            accept;
   logic            present;
   logic            unused_attr;

   assign accept        = req_valid && req_ready;
   assign present       = mem_rsp_data[PRESENT_BIT];
   assign unused_attr   = ^mem_rsp_data[OFF_W-1:1];
   assign req_ready     = (st == WS_IDLE);
   assign mem_req_valid = (st == WS_DIR_REQ) || (st == WS_TBL_REQ);
   assign mem_rsp_ready = (st == WS_DIR_WAIT) || (st == WS_TBL_WAIT);
   assign mem_req_addr  = addr_q;

   assign fill_en  = (st == WS_TBL_WAIT) && mem_rsp_valid && present && !stale_q && !inval;
   assign fill_vpn = lin_q[VA_W-1:OFF_W];
   assign fill_pfn = mem_rsp_data[VA_W-1:OFF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= WS_IDLE;
         lin_q      <= '0;
         addr_q     <= '0;
         stale_q    <= 1'b0;
         resp_valid <= 1'b0;
         resp_pa    <= '0;
         resp_fault <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         stale_q    <= stale_q | inval;
         case (st)
            WS_IDLE: begin
               if (accept) begin
                  if (!pg_en) begin
                     resp_valid <= 1'b1;
                     resp_pa    <= req_lin;
                     resp_fault <= 1'b0;
                  end else if (hit && !inval) begin
                     resp_valid <= 1'b1;
                     resp_pa    <= {hit_pfn, req_lin[OFF_W-1:0]};
                     resp_fault <= 1'b0;
                  end else begin
                     lin_q   <= req_lin;
                     addr_q  <= {dir_pfn, req_lin[VA_W-1 -: IDX_W], {WORD_SHIFT{1'b0}}};
                     stale_q <= inval;
                     st      <= WS_DIR_REQ;
                  end
               end
            end
            WS_DIR_REQ: begin
               if (mem_req_ready) st <= WS_DIR_WAIT;
            end
            WS_DIR_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!present) begin
                     resp_valid <= 1'b1;
                     resp_pa    <= '0;
                     resp_fault <= 1'b1;
                     st         <= WS_IDLE;
                  end else begin
                     addr_q <= {mem_rsp_data[VA_W-1:OFF_W],
                                lin_q[VA_W-IDX_W-1 -: IDX_W], {WORD_SHIFT{1'b0}}};
                     st     <= WS_TBL_REQ;
                  end
               end
            end
            WS_TBL_REQ: begin
               if (mem_req_ready) st <= WS_TBL_WAIT;
            end
            WS_TBL_WAIT: begin
               if (mem_rsp_valid) begin
                  resp_valid <= 1'b1;
                  resp_fault <= !present;
                  resp_pa    <= present ? {mem_rsp_data[VA_W-1:OFF_W], lin_q[OFF_W-1:0]}
                                        : '0;
                  st         <= WS_IDLE;
               end
            end
            default: st <= WS_IDLE;
         endcase
      end
   end

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !pg_en |=> resp_valid && !resp_fault && resp_pa == $past(req_lin)); // R1
   AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      accept && pg_en && hit && !inval |=> resp_valid && !mem_req_valid); // R7
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_ready |-> !mem_req_valid && !req_ready); // R8
   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_fault |-> resp_pa == '0); // R5
   AST_NO_FILL_WHEN_STALE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> !stale_q && !inval); // R12

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
   parameter int IDX_W     = 10,
   parameter int OFF_W     = 12,
   parameter int TLB_DEPTH = 8,
   localparam int VA_W     = 2 * IDX_W + OFF_W,
   localparam int PFN_W    = VA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             base_wr,
   input  logic [PFN_W-1:0] base_pfn,
   input  logic             pg_en,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_lin,
   output logic             resp_valid,
   output logic [VA_W-1:0]  resp_pa,
   output logic             resp_fault,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [VA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   output logic             mem_rsp_ready,
   input  logic [VA_W-1:0]  mem_rsp_data
);

   if (IDX_W < 1 || OFF_W < 3) begin : g_bad_fields
      $error("xlat_walker: index and offset fields too narrow");
   end
   if (TLB_DEPTH < 0) begin : g_bad_tlb
      $error("xlat_walker: TLB_DEPTH must not be negative");
   end

   logic [PFN_W-1:0] dir_pfn_q;
   logic             inval;
   logic             hit;
   logic [PFN_W-1:0] hit_pfn;
   logic             fill_en;
   logic [PFN_W-1:0] fill_vpn;
   logic [PFN_W-1:0] fill_pfn;

   assign inval = flush || base_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dir_pfn_q <= '0;
      else if (base_wr) dir_pfn_q <= base_pfn;
   end

   if (TLB_DEPTH > 0) begin : g_tlb
      xw_tlb #(
         .DEPTH  (TLB_DEPTH),
         .TAG_W  (PFN_W),
         .DATA_W (PFN_W)
      ) i_tlb (
         .clk       (clk),
         .rst_n     (rst_n),
         .inval     (inval),
         .lk_tag    (req_lin[VA_W-1:OFF_W]),
         .lk_hit    (hit),
         .lk_data   (hit_pfn),
         .fill_en   (fill_en),
         .fill_tag  (fill_vpn),
         .fill_data (fill_pfn)
      );
   end else begin : g_no_tlb
      assign hit     = 1'b0;
      assign hit_pfn = '0;
   end

   xw_walk_fsm #(
      .IDX_W (IDX_W),
      .OFF_W (OFF_W),
      .VA_W  (VA_W)
   ) i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_lin       (req_lin),
      .pg_en         (pg_en),
      .dir_pfn       (dir_pfn_q),
      .inval         (inval),
      .hit           (hit),
      .hit_pfn       (hit_pfn),
      .resp_valid    (resp_valid),
      .resp_pa       (resp_pa),
      .resp_fault    (resp_fault),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_ready (mem_rsp_ready),
      .mem_rsp_data  (mem_rsp_data),
      .fill_en       (fill_en),
      .fill_vpn      (fill_vpn),
      .fill_pfn      (fill_pfn)
   );

   AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> dir_pfn_q == $past(base_pfn)); // R10

endmodule

// File: tb/test_xlat_walker.sv
module test_xlat_walker;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush, base_wr, pg_en, req_valid;
   logic [19:0] base_pfn;
   logic [31:0] req_lin;
   logic        req_ready, resp_valid, resp_fault;
   logic [31:0] resp_pa;
   logic        mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
   logic [31:0] mem_req_addr, mem_rsp_data;

   always #5 clk = ~clk;

   xlat_walker i_xlat_walker (
      .clk(clk), .rst_n(rst_n), .flush(flush), .base_wr(base_wr), .base_pfn(base_pfn),
      .pg_en(pg_en), .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
      .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_fault(resp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // Behavioural memory and translation model
   logic [31:0] mem [logic [31:0]];
   logic [19:0] m_tag [8];
   logic [19:0] m_pfn [8];
   bit          m_v [8];
   int          m_ptr;
   bit          m_stale;
   logic [19:0] base_m;

   // Per-cycle expectations
   bit          exp_rv, exp_mv, exp_f;
   logic [31:0] exp_pa;
   string       exp_tag;

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      chk(exp_tag, {31'd0, resp_valid}, {31'd0, exp_rv});
      if (exp_rv) begin
         chk(exp_tag, resp_pa, exp_pa);
         chk(exp_tag, {31'd0, resp_fault}, {31'd0, exp_f});
      end
      chk("R8", {31'd0, mem_req_valid}, {31'd0, exp_mv});
      exp_rv = 1'b0;
   endtask

   function automatic int m_find(logic [19:0] vpn);
      for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == vpn) return i;
      return -1;
   endfunction

   task automatic m_clear();
      for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
   endtask

   function automatic logic [31:0] rd(logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'd0;
   endfunction

   task automatic set_base(logic [19:0] v);
      base_wr = 1'b1; base_pfn = v; exp_tag = "R10";
      tick();
      base_wr = 1'b0; base_m = v; m_clear();
   endtask

   task automatic do_flush();
      flush = 1'b1; exp_tag = "R10";
      tick();
      flush = 1'b0; m_clear();
   endtask

   task automatic xlate(string r, logic [31:0] lin, bit pg, int dly, bit inval_mid);
      int k;
      logic [31:0] da, ta, pde, pte;
      chk("R8", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_lin = lin; pg_en = pg; exp_tag = r;
      k = m_find(lin[31:12]);
      if (!pg || k >= 0) begin
         exp_rv = 1'b1; exp_f = 1'b0; exp_mv = 1'b0;
         exp_pa = !pg ? lin : {m_pfn[k], lin[11:0]};
         tick();
         req_valid = 1'b0;
         return;
      end
      da = {base_m, lin[31:22], 2'b00};
      m_stale = 1'b0;
      exp_mv = 1'b1;
      tick();
      req_valid = 1'b0;
      chk(r, {31'd0, mem_req_valid}, 32'd1);
      chk("R8", {31'd0, req_ready}, 32'd0);
      chk("R2", mem_req_addr, da);
      for (int i = 0; i < dly; i++) begin
         tick();
         chk("R8", mem_req_addr, da);
      end
      mem_req_ready = 1'b1; exp_mv = 1'b0; exp_tag = "R2";
      tick();
      mem_req_ready = 1'b0;
      chk("R8", {31'd0, mem_rsp_ready}, 32'd1);
      if (inval_mid) begin
         flush = 1'b1; exp_tag = "R12";
         tick();
         flush = 1'b0; m_clear(); m_stale = 1'b1;
      end
      for (int i = 0; i < dly; i++) tick();
      pde = rd(da);
      mem_rsp_valid = 1'b1; mem_rsp_data = pde;
      if (!pde[0]) begin
         exp_rv = 1'b1; exp_f = 1'b1; exp_pa = 32'd0; exp_mv = 1'b0; exp_tag = "R5";
         tick();
         mem_rsp_valid = 1'b0;
         return;
      end
      exp_mv = 1'b1; exp_tag = "R3";
      tick();
      mem_rsp_valid = 1'b0;
      ta = {pde[31:12], lin[21:12], 2'b00};
      chk("R3", mem_req_addr, ta);
      mem_req_ready = 1'b1; exp_mv = 1'b0;
      tick();
      mem_req_ready = 1'b0;
      pte = rd(ta);
      mem_rsp_valid = 1'b1; mem_rsp_data = pte; exp_rv = 1'b1;
      if (!pte[0]) begin
         exp_f = 1'b0; exp_f = 1'b1; exp_pa = 32'd0; exp_tag = "R6";
      end else begin
         exp_f = 1'b0; exp_pa = {pte[31:12], lin[11:0]}; exp_tag = "R4";
         if (!m_stale) begin
            m_tag[m_ptr] = lin[31:12]; m_pfn[m_ptr] = pte[31:12]; m_v[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % 8;
         end
      end
      tick();
      mem_rsp_valid = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R8 watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; flush = 1'b0; base_wr = 1'b0; base_pfn = '0; pg_en = 1'b0;
      req_valid = 1'b0; req_lin = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      mem_rsp_data = '0; exp_rv = 1'b0; exp_mv = 1'b0; exp_f = 1'b0; exp_pa = '0;
      exp_tag = "R8"; m_ptr = 0; m_stale = 1'b0; base_m = '0; m_clear();

      // Memory image
      mem[32'h0001_0004] = 32'h0002_0001;            // directory 1, index 1
      mem[32'h0002_000c] = 32'h0ABC_D007;            // page at index 3
      mem[32'h0002_001c] = 32'h1234_5000;            // index 7: not present
      for (int i = 0; i < 8; i++)
         mem[32'h0002_0000 + 32'((16 + i) * 4)] = {20'h50000 + 20'(i), 12'h001};
      mem[32'h0003_0004] = 32'h0004_0001;            // directory 2, index 1
      mem[32'h0004_0044] = 32'h7777_7001;            // index 17

      repeat (3) @(posedge clk);
      #2;
      chk("R8", {31'd0, req_ready}, 32'd1);
      chk("R8", {31'd0, resp_valid}, 32'd0);
      chk("R8", {31'd0, mem_req_valid}, 32'd0);
      rst_n = 1'b1;

      set_base(20'h00010);
      xlate("R1", 32'h1234_5678, 1'b0, 0, 1'b0);
      xlate("R2", 32'h0040_3abc, 1'b1, 2, 1'b0);   // walk, R3/R4
      xlate("R7", 32'h0040_3123, 1'b1, 0, 1'b0);   // hit
      xlate("R1", 32'h0040_3123, 1'b0, 0, 1'b0);   // pass-through despite cached
      xlate("R5", 32'h0140_0000, 1'b1, 1, 1'b0);   // directory fault
      xlate("R11", 32'h0140_0000, 1'b1, 0, 1'b0);  // walks again
      xlate("R6", 32'h0040_7000, 1'b1, 3, 1'b0);   // table fault
      xlate("R11", 32'h0040_7000, 1'b1, 0, 1'b0);
      for (int i = 0; i < 8; i++)
         xlate("R9", 32'h0041_0000 + 32'(i << 12), 1'b1, i % 3, 1'b0);
      xlate("R9", 32'h0040_3abc, 1'b1, 0, 1'b0);   // evicted, walks
      xlate("R9", 32'h0041_1004, 1'b1, 0, 1'b0);   // still cached
      xlate("R9", 32'h0041_0004, 1'b1, 0, 1'b0);   // evicted by refill
      do_flush();
      xlate("R10", 32'h0041_1008, 1'b1, 1, 1'b0);  // walks after flush
      set_base(20'h00030);
      xlate("R10", 32'h0041_1008, 1'b1, 1, 1'b0);  // new directory
      xlate("R7", 32'h0041_1ffc, 1'b1, 0, 1'b0);
      do_flush();
      xlate("R12", 32'h0041_1010, 1'b1, 1, 1'b1);  // flush during walk
      xlate("R12", 32'h0041_1010, 1'b1, 0, 1'b0);  // not cached: walks
      xlate("R7", 32'h0041_1020, 1'b1, 0, 1'b0);
      tick();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule